// File: doc/BRIEF.md
# PRBS-7 Stream Checker with Snapshot Counters

This block watches a byte-wide receive stream and compares it with a locally regenerated PRBS-7 sequence. It has no seed of its own. It loads its shift register from the first received byte, trains on the bytes that follow, and declares lock after a run of clean bytes. Once locked, the shift register runs freely, so each corrupted bit on the line counts as exactly one mismatch. A run of bad bytes drops the lock, and the checker then hunts again.

Three live counters track errored bits, received bytes and end-of-packet events. Software never sees them directly. A write to the 16-bit command/status port either freezes their values into a readable snapshot or freezes and then zeroes them. The status word combines the lock state, a sticky loss-of-sync flag, sticky overflow flags for the byte and packet counters, two packet-generator status inputs and the frozen errored-bit count. A mode input selects whether the errored-bit counter saturates or wraps.

Top module: `prbs_snap_checker`

## Requirements
- R1: After reset, `stat_word`, `snap_bytes` and `snap_pkts` all read zero.
- R2: Bit 8 of `stat_word` (lock) becomes 1 after one seeding byte followed by 8 consecutive error-free bytes. A byte with a mismatch during training restarts the run of 8.
- R3: While locked, 4 consecutive bytes that each contain at least one mismatch clear the lock. A shorter run of bad bytes ended by a clean byte leaves the lock set.
- R4: Bit 13 (loss-of-sync) sets on every transition from locked to unlocked and stays set. It clears only when software writes a word with bit 13 = 1. Writing bit 13 = 0 leaves it unchanged.
- R5: Each received bit that differs from the sequence while locked adds one to the live errored-bit count. Bits 7:0 of `stat_word` change only when a snapshot command is written.
- R6: Writing a word with bit 0 = 1 copies the live error, byte and packet counts into the snapshot and leaves the live counts running.
- R7: Writing a word with bit 1 = 1 copies the live counts into the snapshot and then zeroes the live counts and both overflow flags. An event in the same cycle as the clear is discarded.
- R8: With `cnt_wrap` = 0 the errored-bit count stops at 255. With `cnt_wrap` = 1 it wraps modulo 256.
- R9: The 16-bit byte counter counts every cycle with `rx_valid` = 1, and the 16-bit packet counter counts every cycle with `rx_eop` = 1. Each counter wraps to 0 after 65535, and the wrap sets its sticky overflow flag (bit 9 for bytes, bit 10 for packets).
- R10: Bits 15:14 read 0. Bit 12 follows `pkt_done`, and bit 11 follows `pkt_busy`.
- R11: The reference sequence uses the polynomial x^7 + x^6 + 1, and each byte is consumed MSB first. A clean sequence of that kind, once locked, accumulates no errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte, MSB is the earliest bit |
| rx_eop | input | 1 | End-of-packet event, counted by the packet counter |
| cnt_wrap | input | 1 | 1: error count wraps; 0: error count saturates |
| pkt_done | input | 1 | Packet generator finished flag, reported in bit 12 |
| pkt_busy | input | 1 | Packet generator busy flag, reported in bit 11 |
| reg_wr | input | 1 | Command write strobe |
| reg_wdata | input | 16 | Command word: bit 0 snapshot, bit 1 snapshot and clear, bit 13 clear loss-of-sync |
| stat_word | output | 16 | Registered status word |
| snap_bytes | output | 16 | Frozen byte count |
| snap_pkts | output | 16 | Frozen packet count |

## Verification
The saturation and overflow properties assume that `cnt_wrap` stays constant while the error count sits at its ceiling, and that overflow is judged only between clear commands. The bench changes `cnt_wrap` only during reset and never clears while it waits for a wrap. The lock properties assume that `rx_valid` is the only thing that advances the synchroniser. For this reason the bench drives every byte for exactly one cycle and injects errors only at chosen bit positions. During training it corrupts only the MSB, because the feedback taps then carry the error no further than the same byte.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
  // Sequence generator shape: x^7 + x^6 + 1
  localparam int PRBS_ORD = 7;
  localparam int TAP_HI   = 6;
  localparam int TAP_LO   = 5;

  // Status word field positions (software decodes these)
  localparam int SW_W        = 16;
  localparam int SB_LOSS     = 13;
  localparam int SB_PDONE    = 12;
  localparam int SB_PBUSY    = 11;
  localparam int SB_PKT_OV   = 10;
  localparam int SB_BYTE_OV  = 9;
  localparam int SB_LOCK     = 8;

  // Command bit positions
  localparam int CB_LATCH = 0;
  localparam int CB_CLEAR = 1;

  typedef enum logic [1:0] {
    SY_SEED  = 2'd0,
    SY_TRAIN = 2'd1,
    SY_LOCK  = 2'd2
  } sync_st_e;
endpackage

// File: rtl/prbs_sync.sv
module prbs_sync
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int GOOD_RUN = 8,
  parameter int BAD_RUN  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [DATA_W-1:0]                 in_data,
  output logic                              locked,
  output logic [$clog2(DATA_W+1)-1:0]       err_bits
);
  localparam int NB_W   = $clog2(DATA_W + 1);
  localparam int RUN_MX = (GOOD_RUN > BAD_RUN) ? GOOD_RUN : BAD_RUN;
  localparam int RUN_W  = $clog2(RUN_MX + 1);

  sync_st_e              st_q;
  logic [PRBS_ORD-1:0]   lfsr_q, lfsr_d;
  logic [RUN_W-1:0]      run_q;
  logic [DATA_W-1:0]     mism;
  logic [NB_W-1:0]       nmis;

  // Bit-serial walk over the byte, earliest bit first
  always_comb begin
    logic [PRBS_ORD-1:0] s;
    logic                pb;
    s    = lfsr_q;
    mism = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      pb      = s[TAP_HI] ^ s[TAP_LO];
      mism[i] = pb ^ in_data[i];
      s       = {s[PRBS_ORD-2:0], (st_q == SY_LOCK) ? pb : in_data[i]};
    end
    lfsr_d = s;
    nmis   = '0;
    for (int i = 0; i < DATA_W; i++) nmis = nmis + NB_W'(mism[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SY_SEED;
      lfsr_q <= '0;
      run_q  <= '0;
    end else if (in_valid) begin
      lfsr_q <= lfsr_d;
      case (st_q)
        SY_SEED: begin
          st_q  <= SY_TRAIN;
          run_q <= '0;
        end
        SY_TRAIN: begin
          if (nmis != '0) run_q <= '0;
          else if (run_q == RUN_W'(GOOD_RUN - 1)) begin
            st_q  <= SY_LOCK;
            run_q <= '0;
          end else run_q <= run_q + 1'b1;
        end
        default: begin
          if (nmis == '0) run_q <= '0;
          else if (run_q == RUN_W'(BAD_RUN - 1)) begin
            st_q  <= SY_SEED;
            run_q <= '0;
          end else run_q <= run_q + 1'b1;
        end
      endcase
    end
  end

  assign locked   = (st_q == SY_LOCK);
  assign err_bits = (in_valid && st_q == SY_LOCK) ? nmis : '0;
endmodule

// File: rtl/event_ctr.sv
module event_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt,
  input  logic         clear,
  output logic [W-1:0] cnt,
  output logic         ov
);
  logic [W:0] nxt;
  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      ov  <= 1'b0;
    end else if (evt) begin
      cnt <= nxt[W-1:0];
      if (nxt[W]) ov <= 1'b1;
    end
  end
endmodule

// File: rtl/prbs_counters.sv
module prbs_counters #(
  parameter int ERR_W = 8,
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_evt,
  input  logic             pkt_evt,
  input  logic [INC_W-1:0] err_inc,
  input  logic             wrap_mode,
  input  logic             latch,
  input  logic             clear,
  output logic [ERR_W-1:0] err_live,
  output logic [ERR_W-1:0] err_snap,
  output logic [CNT_W-1:0] byte_snap,
  output logic [CNT_W-1:0] pkt_snap,
  output logic             byte_ov,
  output logic             pkt_ov
);
  logic [CNT_W-1:0] byte_live, pkt_live;
  logic [ERR_W:0]   esum;
  logic [ERR_W-1:0] err_d;

  assign esum  = {1'b0, err_live} + (ERR_W + 1)'(err_inc);
  assign err_d = (wrap_mode || !esum[ERR_W]) ? esum[ERR_W-1:0] : '1;

  always_ff @(posedge clk) begin
    if (rst || clear) err_live <= '0;
    else              err_live <= err_d;
  end

  event_ctr #(.W(CNT_W)) u_bytes (
    .clk(clk), .rst(rst), .evt(byte_evt), .clear(clear),
    .cnt(byte_live), .ov(byte_ov)
  );

  event_ctr #(.W(CNT_W)) u_pkts (
    .clk(clk), .rst(rst), .evt(pkt_evt), .clear(clear),
    .cnt(pkt_live), .ov(pkt_ov)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_snap  <= '0;
      byte_snap <= '0;
      pkt_snap  <= '0;
    end else if (latch || clear) begin
      err_snap  <= err_live;
      byte_snap <= byte_live;
      pkt_snap  <= pkt_live;
    end
  end
endmodule

// File: rtl/prbs_snap_checker.sv
module prbs_snap_checker
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 8,
  parameter int CNT_W    = 16,
  parameter int GOOD_RUN = 8,
  parameter int BAD_RUN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_eop,
  input  logic             cnt_wrap,
  input  logic             pkt_done,
  input  logic             pkt_busy,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      stat_word,
  output logic [15:0]      snap_bytes,
  output logic [15:0]      snap_pkts
);
  localparam int NB_W = $clog2(DATA_W + 1);

  logic             locked, lock_prev, sync_loss;
  logic [NB_W-1:0]  err_bits;
  logic             latch_cmd, clr_cmd, loss_clr;
  logic [ERR_W-1:0] err_live, err_snap;
  logic [CNT_W-1:0] byte_snap, pkt_snap;
  logic             byte_ov, pkt_ov;
  logic             unused_wbits;

  assign latch_cmd    = reg_wr && reg_wdata[CB_LATCH];
  assign clr_cmd      = reg_wr && reg_wdata[CB_CLEAR];
  assign loss_clr     = reg_wr && reg_wdata[SB_LOSS];
  assign unused_wbits = ^{reg_wdata[15:14], reg_wdata[12:2]};

  prbs_sync #(.DATA_W(DATA_W), .GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) u_sync (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .locked(locked), .err_bits(err_bits)
  );

  prbs_counters #(.ERR_W(ERR_W), .CNT_W(CNT_W), .INC_W(NB_W)) u_cnt (
    .clk(clk), .rst(rst), .byte_evt(rx_valid), .pkt_evt(rx_eop),
    .err_inc(err_bits), .wrap_mode(cnt_wrap), .latch(latch_cmd), .clear(clr_cmd),
    .err_live(err_live), .err_snap(err_snap), .byte_snap(byte_snap),
    .pkt_snap(pkt_snap), .byte_ov(byte_ov), .pkt_ov(pkt_ov)
  );

  // Sticky loss-of-sync: a lock drop outranks a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_prev <= 1'b0;
      sync_loss <= 1'b0;
    end else begin
      lock_prev <= locked;
      if (lock_prev && !locked) sync_loss <= 1'b1;
      else if (loss_clr)        sync_loss <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_word  <= '0;
      snap_bytes <= '0;
      snap_pkts  <= '0;
    end else begin
      stat_word             <= '0;
      stat_word[ERR_W-1:0]  <= err_snap;
      stat_word[SB_LOCK]    <= locked;
      stat_word[SB_BYTE_OV] <= byte_ov;
      stat_word[SB_PKT_OV]  <= pkt_ov;
      stat_word[SB_PBUSY]   <= pkt_busy;
      stat_word[SB_PDONE]   <= pkt_done;
      stat_word[SB_LOSS]    <= sync_loss;
      snap_bytes            <= 16'(byte_snap);
      snap_pkts             <= 16'(pkt_snap);
    end
  end
endmodule

// File: rtl/prbs_snap_sva.sv
module prbs_snap_sva #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             locked,
  input logic             sync_loss,
  input logic             latch_cmd,
  input logic             clr_cmd,
  input logic             cnt_wrap,
  input logic             byte_ov,
  input logic [ERR_W-1:0] err_live,
  input logic [ERR_W-1:0] err_snap,
  input logic [15:0]      stat_word
);
  p_lock_on_byte_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(rx_valid));

  p_lock_bit_r2: assert property (@(posedge clk) disable iff (rst)
    stat_word[8] == $past(locked));

  p_drop_on_byte_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(rx_valid));

  p_loss_flag_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |=> sync_loss);

  p_snap_copy_r6: assert property (@(posedge clk) disable iff (rst)
    latch_cmd |=> err_snap == $past(err_live));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> err_live == '0);

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wrap && !clr_cmd && err_live == '1) |=> err_live == '1);

  p_ov_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_ov && !clr_cmd) |=> byte_ov);
endmodule

bind prbs_snap_checker prbs_snap_sva #(.ERR_W(ERR_W)) u_sva (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .locked(locked),
  .sync_loss(sync_loss), .latch_cmd(latch_cmd), .clr_cmd(clr_cmd),
  .cnt_wrap(cnt_wrap), .byte_ov(byte_ov), .err_live(err_live),
  .err_snap(err_snap), .stat_word(stat_word)
);

// File: tb/prbs_snap_checker_tb.sv
module prbs_snap_checker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_eop = 1'b0;
  logic        cnt_wrap = 1'b0;
  logic        pkt_done = 1'b0;
  logic        pkt_busy = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] stat_word, snap_bytes, snap_pkts;

  int n_cmp = 0;
  int n_bad = 0;
  logic [6:0] g = 7'h5A;

  always #4 clk = ~clk;

  prbs_snap_checker u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_eop(rx_eop),
    .cnt_wrap(cnt_wrap), .pkt_done(pkt_done), .pkt_busy(pkt_busy),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .stat_word(stat_word), .snap_bytes(snap_bytes), .snap_pkts(snap_pkts)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_byte();
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      b[i] = g[6] ^ g[5];
      g    = {g[5:0], b[i]};
    end
    return b;
  endfunction

  task automatic send(input logic [7:0] emask, input logic eop);
    rx_valid = 1'b1;
    rx_data  = next_byte() ^ emask;
    rx_eop   = eop;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_eop   = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    reg_wr    = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic wrap);
    rst      = 1'b1;
    cnt_wrap = wrap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic lock_up();
    for (int i = 0; i < 9; i++) send(8'h00, 1'b0);
    settle();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R1 status after reset", stat_word, 0);
    chk("R1 snap_bytes after reset", snap_bytes, 0);
    chk("R1 snap_pkts after reset", snap_pkts, 0);
    pkt_done = 1'b1;
    settle();
    chk("R10 done bit, reserved zero", stat_word & 16'hF800, 16'h1000);
    pkt_done = 1'b0;
    pkt_busy = 1'b1;
    settle();
    chk("R10 busy bit", stat_word & 16'hF800, 16'h0800);
    pkt_busy = 1'b0;
  endtask

  task automatic t_lock();
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) send(8'h00, 1'b0);
    settle();
    chk("R2 no lock after seed+7", stat_word[8], 0);
    send(8'h00, 1'b0);
    settle();
    chk("R2 lock after seed+8", stat_word[8], 1);
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) send(8'h00, 1'b0);
    send(8'h80, 1'b0);
    for (int i = 0; i < 7; i++) send(8'h00, 1'b0);
    settle();
    chk("R2 training restarted by error", stat_word[8], 0);
    send(8'h00, 1'b0);
    settle();
    chk("R2 lock after fresh run", stat_word[8], 1);
    wr(16'h0002);
    for (int i = 0; i < 200; i++) send(8'h00, 1'b0);
    wr(16'h0001);
    settle();
    chk("R11 clean PRBS-7 stays error free", stat_word[7:0], 0);
    chk("R11 still locked", stat_word[8], 1);
  endtask

  task automatic t_errs();
    do_reset(1'b0);
    lock_up();
    wr(16'h0002);
    for (int i = 0; i < 40; i++) begin
      if (i % 8 == 1)      send(8'h01, 1'b0);
      else if (i % 8 == 4) send(8'h81, 1'b0);
      else                 send(8'h00, 1'b0);
    end
    settle();
    chk("R5 count hidden until snapshot", stat_word[7:0], 0);
    wr(16'h0001);
    settle();
    chk("R5 errored bits counted", stat_word[7:0], 15);
    send(8'h24, 1'b0);
    settle();
    chk("R6 snapshot frozen", stat_word[7:0], 15);
    wr(16'h0001);
    settle();
    chk("R6 live count kept running", stat_word[7:0], 17);
    wr(16'h0002);
    settle();
    chk("R7 clear still snapshots", stat_word[7:0], 17);
    wr(16'h0001);
    settle();
    chk("R7 live count zeroed", stat_word[7:0], 0);
  endtask

  task automatic t_sat(input logic wrap, input int exp);
    do_reset(wrap);
    lock_up();
    wr(16'h0002);
    for (int i = 0; i < 100; i++) begin
      send(8'h07, 1'b0);
      send(8'h00, 1'b0);
    end
    wr(16'h0001);
    settle();
    chk(wrap ? "R8 wrap mode 300 errors" : "R8 saturate mode 300 errors",
        stat_word[7:0], exp);
    chk("R8 lock kept through spaced errors", stat_word[8], 1);
  endtask

  task automatic t_loss();
    do_reset(1'b0);
    lock_up();
    for (int i = 0; i < 3; i++) send(8'h10, 1'b0);
    send(8'h00, 1'b0);
    settle();
    chk("R3 three bad bytes keep lock", stat_word[8], 1);
    chk("R4 no loss flag yet", stat_word[13], 0);
    for (int i = 0; i < 4; i++) send(8'h10, 1'b0);
    settle();
    chk("R3 four bad bytes drop lock", stat_word[8], 0);
    chk("R4 loss flag set", stat_word[13], 1);
    wr(16'h0000);
    settle();
    chk("R4 zero write keeps flag", stat_word[13], 1);
    lock_up();
    chk("R4 flag stays after relock", stat_word[13], 1);
    wr(16'h2000);
    settle();
    chk("R4 flag cleared by write", stat_word[13], 0);
    chk("R4 lock unaffected by flag clear", stat_word[8], 1);
  endtask

  task automatic t_ovf();
    do_reset(1'b0);
    lock_up();
    wr(16'h0002);
    for (int i = 0; i < 20; i++) send(8'h00, (i % 7) == 3);
    wr(16'h0001);
    settle();
    chk("R9 byte count", snap_bytes, 20);
    chk("R9 packet count", snap_pkts, 3);
    wr(16'h0002);
    for (int i = 0; i < 65535; i++) send(8'h00, 1'b1);
    settle();
    chk("R9 no overflow at 65535", stat_word[10:9], 0);
    send(8'h00, 1'b1);
    settle();
    chk("R9 both overflow flags set", stat_word[10:9], 3);
    send(8'h00, 1'b0);
    wr(16'h0001);
    settle();
    chk("R9 byte counter wrapped", snap_bytes, 1);
    chk("R9 packet counter wrapped", snap_pkts, 0);
    wr(16'h0002);
    settle();
    chk("R7 clear drops overflow flags", stat_word[10:9], 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_lock();
        t_errs();
        t_sat(1'b0, 255);
        t_sat(1'b1, 44);
        t_loss();
        t_ovf();
      end
      begin
        repeat (190000) @(negedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule